// File: doc/BRIEF.md
# Pixel Cluster Seed Finder

This block watches one frame of pedestal-corrected pixel samples as it streams past in raster order, one sample per accepted clock. It keeps the whole frame in an on-chip buffer and tracks the single strongest pixel while the frame arrives. Once the last pixel has been taken, it reads back the square neighbourhood around that strongest pixel (the seed) and adds it up.

The neighbourhood is either 3x3 or 5x5, picked per frame by a select input. Positions of the window that lie beyond the array border add nothing. The result holds the seed's row, column and value, the window sum, and a noise figure taken with the frame. A single-cycle done strobe marks the result. Dividing the sum by the noise figure, which gives the cluster signal-to-noise, is left to downstream logic.

Top module: `cluster_seed_finder`

## Requirements
- R1: After reset, every result output reads zero and `done_o` is low.
- R2: The reported seed is the pixel with the largest signed value in the frame. Its row is the index of the line it arrived in, with row 0 the first line. Its column is its position within that line, with column 0 the first pixel.
- R3: When several pixels share the largest value, the seed is the one that arrived first in the frame.
- R4: With `win_5x5_i` low on the end-of-frame beat, `clus_sum_o` is the signed sum of the 3x3 pixels centred on the seed.
- R5: With `win_5x5_i` high on the end-of-frame beat, `clus_sum_o` is the signed sum of the 5x5 pixels centred on the seed. The select value on any other beat has no effect.
- R6: Window positions whose row or column lies outside the array add zero to the sum. This holds for seeds on edges and corners.
- R7: `done_o` is high for exactly one cycle per frame. It rises no more than 40 cycles after the end-of-frame beat, and only after an end-of-frame beat.
- R8: Once `done_o` has pulsed, the result outputs keep their values until the next start-of-frame beat. In the cycle after that beat, `seed_val_o` and `clus_sum_o` read zero.
- R9: `noise_o` presents the value that was on `noise_i` during the end-of-frame beat, and it is updated together with the result.
- R10: Values are two's-complement. A frame of only negative pixels yields the least negative pixel as seed and a correctly signed, negative sum.
- R11: Cycles with `pix_vld_i` low neither advance the pixel position nor touch the result, so a stream with gaps gives the same result as one without.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld_i | input | 1 | Pixel beat valid |
| pix_sof_i | input | 1 | Marks the first pixel of a frame |
| pix_eof_i | input | 1 | Marks the last pixel of a frame |
| pix_val_i | input | PIX_W (13) | Signed pixel value |
| win_5x5_i | input | 1 | Window select, 0 = 3x3, 1 = 5x5, taken on the end-of-frame beat |
| noise_i | input | NOISE_W (12) | Noise figure, taken on the end-of-frame beat |
| seed_row_o | output | clog2(ROWS) (6) | Row of the seed |
| seed_col_o | output | clog2(COLS) (6) | Column of the seed |
| seed_val_o | output | PIX_W (13) | Signed seed value |
| clus_sum_o | output | SUM_W (18) | Signed window sum |
| noise_o | output | NOISE_W (12) | Noise figure captured with the frame |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with an 8 by 8 array in place of 64 by 64, keeping the 13-bit pixel and 18-bit sum widths. At this size a frame is only 64 beats long, so many frames fit in one short run. Seeds can be placed on every edge and corner cheaply, which makes the clipped 3x3 and 5x5 windows (down to 9 of 25 positions) easy to reach. The full-scale 13-bit peak can still be combined with a 5x5 window to test the width of the sum.

// File: rtl/cseed_pkg.sv
package cseed_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_SCAN  = 2'd1,
    WS_FLUSH = 2'd2
  } wsum_state_e;

  // half width of the summing window for a given select
  function automatic logic signed [2:0] win_half(input logic sel5);
    return sel5 ? 3'sd2 : 3'sd1;
  endfunction

endpackage

// File: rtl/cseed_frame_store.sv
module cseed_frame_store #(
  parameter int DEPTH = 4096,
  parameter int AW    = 12,
  parameter int DW    = 13
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
    if (re_i) begin
      rdata_q <= mem[raddr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/cseed_peak_tracker.sv
module cseed_peak_tracker #(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int PIX_W = 13,
  parameter int RW    = 6,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic             sof_i,
  input  logic [PIX_W-1:0] val_i,
  output logic [RW-1:0]    wr_row_o,
  output logic [CW-1:0]    wr_col_o,
  output logic [RW-1:0]    pk_row_o,
  output logic [CW-1:0]    pk_col_o,
  output logic [PIX_W-1:0] pk_val_o
);

  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  logic [RW-1:0]    row_q, row_d, cur_row;
  logic [CW-1:0]    col_q, col_d, cur_col;
  logic [RW-1:0]    pk_row_q, pk_row_d;
  logic [CW-1:0]    pk_col_q, pk_col_d;
  logic [PIX_W-1:0] pk_val_q, pk_val_d;
  logic             take;

  always_comb begin
    cur_row = sof_i ? '0 : row_q;
    cur_col = sof_i ? '0 : col_q;
    row_d   = row_q;
    col_d   = col_q;
    if (vld_i) begin
      if (cur_col == LAST_COL) begin
        col_d = '0;
        row_d = cur_row + 1'b1;
      end else begin
        col_d = cur_col + 1'b1;
        row_d = cur_row;
      end
    end
    // strict compare keeps the earliest of equal maxima
    take     = vld_i && (sof_i || ($signed(val_i) > $signed(pk_val_q)));
    pk_row_d = take ? cur_row : pk_row_q;
    pk_col_d = take ? cur_col : pk_col_q;
    pk_val_d = take ? val_i   : pk_val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q    <= '0;
      col_q    <= '0;
      pk_row_q <= '0;
      pk_col_q <= '0;
      pk_val_q <= '0;
    end else begin
      row_q    <= row_d;
      col_q    <= col_d;
      pk_row_q <= pk_row_d;
      pk_col_q <= pk_col_d;
      pk_val_q <= pk_val_d;
    end
  end

  assign wr_row_o = cur_row;
  assign wr_col_o = cur_col;
  assign pk_row_o = pk_row_q;
  assign pk_col_o = pk_col_q;
  assign pk_val_o = pk_val_q;

endmodule

// File: rtl/cseed_window_summer.sv
module cseed_window_summer
  import cseed_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int PIX_W = 13,
  parameter int SUM_W = 18,
  parameter int RW    = 6,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             win5_i,
  input  logic [RW-1:0]    seed_row_i,
  input  logic [CW-1:0]    seed_col_i,
  output logic             rd_en_o,
  output logic [RW-1:0]    rd_row_o,
  output logic [CW-1:0]    rd_col_o,
  input  logic [PIX_W-1:0] rd_data_i,
  output logic             finish_o,
  output logic [SUM_W-1:0] sum_o
);

  localparam logic signed [RW+1:0] ROWS_S = (RW+2)'(ROWS);
  localparam logic signed [CW+1:0] COLS_S = (CW+2)'(COLS);

  wsum_state_e       st_q, st_d;
  logic              win5_q, win5_d;
  logic signed [2:0] dy_q, dy_d, dx_q, dx_d, half;
  logic              iss_vld_q, iss_vld_d, iss_inb_q, iss_inb_d;
  logic [SUM_W-1:0]  acc_q, acc_d, term;
  logic signed [RW+1:0] r_s;
  logic signed [CW+1:0] c_s;
  logic              inb;

  always_comb begin
    half = win_half(win5_q);
    r_s  = $signed({2'b00, seed_row_i}) + $signed({{(RW-1){dy_q[2]}}, dy_q});
    c_s  = $signed({2'b00, seed_col_i}) + $signed({{(CW-1){dx_q[2]}}, dx_q});
    inb  = (r_s >= 0) && (r_s < ROWS_S) && (c_s >= 0) && (c_s < COLS_S);
    term = iss_inb_q ? {{(SUM_W-PIX_W){rd_data_i[PIX_W-1]}}, rd_data_i} : '0;
    acc_d = iss_vld_q ? (acc_q + term) : acc_q;

    st_d      = st_q;
    win5_d    = win5_q;
    dy_d      = dy_q;
    dx_d      = dx_q;
    iss_vld_d = 1'b0;
    iss_inb_d = 1'b0;
    rd_en_o   = 1'b0;
    finish_o  = 1'b0;

    unique case (st_q)
      WS_IDLE: begin
        if (start_i) begin
          st_d   = WS_SCAN;
          win5_d = win5_i;
          dy_d   = -win_half(win5_i);
          dx_d   = -win_half(win5_i);
          acc_d  = '0;
        end
      end
      WS_SCAN: begin
        rd_en_o   = inb;
        iss_vld_d = 1'b1;
        iss_inb_d = inb;
        if (dx_q == half) begin
          dx_d = -half;
          if (dy_q == half) begin
            st_d = WS_FLUSH;
          end else begin
            dy_d = dy_q + 3'sd1;
          end
        end else begin
          dx_d = dx_q + 3'sd1;
        end
      end
      WS_FLUSH: begin
        finish_o = 1'b1;
        st_d     = WS_IDLE;
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= WS_IDLE;
      win5_q    <= 1'b0;
      dy_q      <= '0;
      dx_q      <= '0;
      iss_vld_q <= 1'b0;
      iss_inb_q <= 1'b0;
      acc_q     <= '0;
    end else begin
      st_q      <= st_d;
      win5_q    <= win5_d;
      dy_q      <= dy_d;
      dx_q      <= dx_d;
      iss_vld_q <= iss_vld_d;
      iss_inb_q <= iss_inb_d;
      acc_q     <= acc_d;
    end
  end

  assign rd_row_o = r_s[RW-1:0];
  assign rd_col_o = c_s[CW-1:0];
  assign sum_o    = acc_d;

endmodule

// File: rtl/cluster_seed_finder.sv
module cluster_seed_finder #(
  parameter int ROWS    = 64,
  parameter int COLS    = 64,
  parameter int PIX_W   = 13,
  parameter int SUM_W   = 18,
  parameter int NOISE_W = 12,
  parameter int RW      = $clog2(ROWS),
  parameter int CW      = $clog2(COLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_vld_i,
  input  logic               pix_sof_i,
  input  logic               pix_eof_i,
  input  logic [PIX_W-1:0]   pix_val_i,
  input  logic               win_5x5_i,
  input  logic [NOISE_W-1:0] noise_i,
  output logic [RW-1:0]      seed_row_o,
  output logic [CW-1:0]      seed_col_o,
  output logic [PIX_W-1:0]   seed_val_o,
  output logic [SUM_W-1:0]   clus_sum_o,
  output logic [NOISE_W-1:0] noise_o,
  output logic               done_o
);

  localparam int AW    = RW + CW;
  localparam int DEPTH = ROWS * (1 << CW);

  // reset: asserted at once, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [RW-1:0]    wr_row, pk_row, rd_row;
  logic [CW-1:0]    wr_col, pk_col, rd_col;
  logic [PIX_W-1:0] pk_val, rd_data;
  logic             rd_en, finish, start;
  logic [SUM_W-1:0] sum_w;

  assign start = pix_vld_i && pix_eof_i;

  cseed_peak_tracker #(
    .ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .RW(RW), .CW(CW)
  ) u_peak (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .vld_i    (pix_vld_i),
    .sof_i    (pix_sof_i),
    .val_i    (pix_val_i),
    .wr_row_o (wr_row),
    .wr_col_o (wr_col),
    .pk_row_o (pk_row),
    .pk_col_o (pk_col),
    .pk_val_o (pk_val)
  );

  cseed_frame_store #(
    .DEPTH(DEPTH), .AW(AW), .DW(PIX_W)
  ) u_store (
    .clk     (clk),
    .we_i    (pix_vld_i),
    .waddr_i ({wr_row, wr_col}),
    .wdata_i (pix_val_i),
    .re_i    (rd_en),
    .raddr_i ({rd_row, rd_col}),
    .rdata_o (rd_data)
  );

  cseed_window_summer #(
    .ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .SUM_W(SUM_W), .RW(RW), .CW(CW)
  ) u_sum (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start),
    .win5_i     (win_5x5_i),
    .seed_row_i (pk_row),
    .seed_col_i (pk_col),
    .rd_en_o    (rd_en),
    .rd_row_o   (rd_row),
    .rd_col_o   (rd_col),
    .rd_data_i  (rd_data),
    .finish_o   (finish),
    .sum_o      (sum_w)
  );

  logic [NOISE_W-1:0] nz_cap_q, nz_cap_d;
  logic [RW-1:0]      res_row_q, res_row_d;
  logic [CW-1:0]      res_col_q, res_col_d;
  logic [PIX_W-1:0]   res_val_q, res_val_d;
  logic [SUM_W-1:0]   res_sum_q, res_sum_d;
  logic [NOISE_W-1:0] res_nz_q, res_nz_d;
  logic               done_q, done_d;

  always_comb begin
    nz_cap_d  = start ? noise_i : nz_cap_q;
    res_row_d = res_row_q;
    res_col_d = res_col_q;
    res_val_d = res_val_q;
    res_sum_d = res_sum_q;
    res_nz_d  = res_nz_q;
    done_d    = finish;
    if (finish) begin
      res_row_d = pk_row;
      res_col_d = pk_col;
      res_val_d = pk_val;
      res_sum_d = sum_w;
      res_nz_d  = nz_cap_q;
    end else if (pix_vld_i && pix_sof_i) begin
      res_row_d = '0;
      res_col_d = '0;
      res_val_d = '0;
      res_sum_d = '0;
      res_nz_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      nz_cap_q  <= '0;
      res_row_q <= '0;
      res_col_q <= '0;
      res_val_q <= '0;
      res_sum_q <= '0;
      res_nz_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      nz_cap_q  <= nz_cap_d;
      res_row_q <= res_row_d;
      res_col_q <= res_col_d;
      res_val_q <= res_val_d;
      res_sum_q <= res_sum_d;
      res_nz_q  <= res_nz_d;
      done_q    <= done_d;
    end
  end

  assign seed_row_o = res_row_q;
  assign seed_col_o = res_col_q;
  assign seed_val_o = res_val_q;
  assign clus_sum_o = res_sum_q;
  assign noise_o    = res_nz_q;
  assign done_o     = done_q;

endmodule

// File: rtl/cluster_seed_chk.sv
module cluster_seed_chk #(
  parameter int PIX_W   = 13,
  parameter int SUM_W   = 18,
  parameter int RW      = 6,
  parameter int CW      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_vld_i,
  input logic             pix_sof_i,
  input logic             pix_eof_i,
  input logic [RW-1:0]    seed_row_o,
  input logic [CW-1:0]    seed_col_o,
  input logic [PIX_W-1:0] seed_val_o,
  input logic [SUM_W-1:0] clus_sum_o,
  input logic             done_o
);

  logic held_q, armed_q;
  int   seed_x25, sum_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (pix_vld_i && pix_sof_i) held_q <= 1'b0;
      else if (done_o)            held_q <= 1'b1;
      if (pix_vld_i && pix_eof_i) armed_q <= 1'b1;
      else if (done_o)            armed_q <= 1'b0;
    end
  end

  always_comb begin
    seed_x25 = 25 * int'($signed(seed_val_o));
    sum_i    = int'($signed(clus_sum_o));
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> armed_q);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !(pix_vld_i && pix_sof_i)) |=>
      ($stable(clus_sum_o) && $stable(seed_val_o) && $stable(seed_row_o) && $stable(seed_col_o)));

  p_clear_on_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && pix_sof_i && !done_o) |=> (clus_sum_o == '0 && seed_val_o == '0));

  // every in-window pixel is at most the seed, clipped positions add zero
  p_sum_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !seed_val_o[PIX_W-1]) |-> (sum_i <= seed_x25));

endmodule

bind cluster_seed_finder cluster_seed_chk #(
  .PIX_W(PIX_W), .SUM_W(SUM_W), .RW(RW), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_vld_i  (pix_vld_i),
  .pix_sof_i  (pix_sof_i),
  .pix_eof_i  (pix_eof_i),
  .seed_row_o (seed_row_o),
  .seed_col_o (seed_col_o),
  .seed_val_o (seed_val_o),
  .clus_sum_o (clus_sum_o),
  .done_o     (done_o)
);

// File: tb/sim_cluster_seed_finder.sv
`timescale 1ns/1ps
module sim_cluster_seed_finder;

  localparam int ROWS = 8, COLS = 8, PIX_W = 13, SUM_W = 18, NOISE_W = 12;
  localparam int RW = 3, CW = 3, NPIX = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_vld, pix_sof, pix_eof, win5;
  logic [PIX_W-1:0]   pix_val;
  logic [NOISE_W-1:0] noise_in;
  logic [RW-1:0]      seed_row;
  logic [CW-1:0]      seed_col;
  logic [PIX_W-1:0]   seed_val;
  logic [SUM_W-1:0]   clus_sum;
  logic [NOISE_W-1:0] noise_out;
  logic               done;

  always #10 clk = ~clk;

  cluster_seed_finder #(
    .ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .SUM_W(SUM_W), .NOISE_W(NOISE_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .pix_vld_i(pix_vld), .pix_sof_i(pix_sof),
    .pix_eof_i(pix_eof), .pix_val_i(pix_val), .win_5x5_i(win5), .noise_i(noise_in),
    .seed_row_o(seed_row), .seed_col_o(seed_col), .seed_val_o(seed_val),
    .clus_sum_o(clus_sum), .noise_o(noise_out), .done_o(done)
  );

  int n_chk = 0, n_err = 0;
  int frm [NPIX];
  int e_row, e_col, e_val, e_sum;

  // vectors: kind, seed row, seed col, peak, win5, gaps
  localparam int NV = 7;
  localparam int TV [NV][6] = '{
    '{0, 3, 4,  200, 0, 0},
    '{0, 3, 4,  200, 1, 1},
    '{2, 0, 0,  500, 0, 0},
    '{2, 7, 7,  900, 1, 0},
    '{2, 0, 5, 4095, 1, 1},
    '{1, 6, 1,  -20, 0, 0},
    '{2, 1, 6, 1000, 1, 0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int kind, input int sr, input int sc, input int pk);
    for (int i = 0; i < NPIX; i++) begin
      if (kind == 0)      frm[i] = ((i * 7) % 9) - 4;
      else if (kind == 1) frm[i] = -100 - (i % 13);
      else                frm[i] = ((i * 5) % 11) * 3;
    end
    if (kind == 2) begin
      for (int dr = -2; dr <= 2; dr++)
        for (int dc = -2; dc <= 2; dc++)
          if (sr+dr >= 0 && sr+dr < ROWS && sc+dc >= 0 && sc+dc < COLS)
            frm[(sr+dr)*COLS + sc+dc] = pk/4 + dr*5 - dc*3;
    end
    frm[sr*COLS + sc] = pk;
  endtask

  // reference: strictly greater keeps the first maximum; clipped window
  task automatic model(input int w5);
    int h;
    h = w5 ? 2 : 1;
    e_val = frm[0]; e_row = 0; e_col = 0;
    for (int i = 1; i < NPIX; i++)
      if (frm[i] > e_val) begin
        e_val = frm[i]; e_row = i / COLS; e_col = i % COLS;
      end
    e_sum = 0;
    for (int dr = -h; dr <= h; dr++)
      for (int dc = -h; dc <= h; dc++)
        if (e_row+dr >= 0 && e_row+dr < ROWS && e_col+dc >= 0 && e_col+dc < COLS)
          e_sum += frm[(e_row+dr)*COLS + e_col+dc];
  endtask

  task automatic send_frame(input int w5, input int nz, input int gaps);
    for (int i = 0; i < NPIX; i++) begin
      if (gaps != 0 && (i % 3) == 1) begin
        @(negedge clk);
        pix_vld = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
        pix_val = 13'h0aa; win5 = 1'b1;
      end
      @(negedge clk);
      pix_vld  = 1'b1;
      pix_sof  = (i == 0);
      pix_eof  = (i == NPIX - 1);
      pix_val  = PIX_W'(frm[i]);
      win5     = (i == NPIX - 1) ? w5[0] : ~w5[0];
      noise_in = (i == NPIX - 1) ? NOISE_W'(nz) : '1;
    end
    @(negedge clk);
    pix_vld = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
  endtask

  task automatic wait_check(input string lbl, input int w5, input int nz);
    int n;
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk({lbl, " R7 done seen"}, int'(done), 1);
    chk({lbl, " R2 seed row"}, int'(seed_row), e_row);
    chk({lbl, " R2 seed col"}, int'(seed_col), e_col);
    chk({lbl, " R2 seed value"}, int'($signed(seed_val)), e_val);
    chk({lbl, w5 ? " R5 sum 5x5" : " R4 sum 3x3"}, int'($signed(clus_sum)), e_sum);
    chk({lbl, " R9 noise"}, int'(noise_out), nz);
    @(negedge clk);
    chk({lbl, " R7 single pulse"}, int'(done), 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL R7 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    int hr, hs;
    rst_n = 1'b0; pix_vld = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
    pix_val = '0; win5 = 1'b0; noise_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 sum", int'(clus_sum), 0);
    chk("R1 seed value", int'(seed_val), 0);
    chk("R1 seed pos", int'({seed_row, seed_col}), 0);
    chk("R1 noise", int'(noise_out), 0);

    // vector walk; edge/corner seeds cover R6, negative frame R10, gaps R11
    for (int v = 0; v < NV; v++) begin
      fill(TV[v][0], TV[v][1], TV[v][2], TV[v][3]);
      model(TV[v][4]);
      send_frame(TV[v][4], 17 * v + 3, TV[v][5]);
      wait_check($sformatf("vec%0d%s%s", v,
                 (TV[v][0] == 1) ? " R10" : "",
                 (TV[v][5] != 0) ? " R11" : ""), TV[v][4], 17 * v + 3);
    end

    // R3 tie: two equal maxima, earlier one wins
    fill(0, 1, 2, 300);
    frm[5*COLS + 5] = 300;
    model(0);
    send_frame(0, 77, 0);
    wait_check("tie R3", 0, 77);
    chk("R3 tie row", int'(seed_row), 1);
    chk("R3 tie col", int'(seed_col), 2);

    // R8 hold then clear on start of frame
    hr = int'($signed(clus_sum));
    hs = int'($signed(seed_val));
    repeat (6) begin
      @(negedge clk);
      pix_vld = 1'b0; pix_val = 13'h111; pix_eof = 1'b1; win5 = 1'b1;
    end
    pix_eof = 1'b0;
    chk("R8 sum held", int'($signed(clus_sum)), hr);
    chk("R8 seed held", int'($signed(seed_val)), hs);
    @(negedge clk);
    pix_vld = 1'b1; pix_sof = 1'b1; pix_val = 13'd55;
    @(negedge clk);
    pix_vld = 1'b0; pix_sof = 1'b0;
    chk("R8 sum cleared", int'(clus_sum), 0);
    chk("R8 seed cleared", int'(seed_val), 0);

    // fresh frame after the partial one, corner seed with 3x3 window (R6)
    fill(2, 7, 0, 1200);
    model(0);
    send_frame(0, 4095, 1);
    wait_check("corner R6", 0, 4095);

    finish_run();
  end

endmodule